// File: doc/BRIEF.md
# Serial-Loaded Cartridge Mapper Register Set

This block sits on the cartridge side of a game console's CPU bus. It holds four small registers (a control word, two character-bank values and a program-bank value) that software cannot write in one bus cycle. Instead, each register is filled one bit at a time over five consecutive writes into the upper half of the CPU address space. Only bit 0 of each written byte is used, and the bits arrive least significant first. The fifth write moves the assembled word into the register picked by two address bits. A write with data bit 7 set aborts a partly assembled word and forces the control word's upper mode bits on.

The two low bits of the control word choose how the picture unit's four logical nametable windows fold onto two physical pages of console video RAM. The block turns any picture-unit address into the page-select line for that RAM. All four register values are also presented as plain outputs, so that the banking logic next to this block can use them.

CPU writes enter as a valid/ready stream. Every register update completes in one cycle, so ready is tied high: the block never applies back-pressure, and a write is taken in any cycle where valid is high. The picture-unit address and the page-select output are plain combinational pins.

Top module: `serial_mapper_ctrl`

## Requirements
- R1: Five accepted writes into the upper half of the CPU address space (address bit 15 = 1, data bit 7 = 0) commit one register. Only data bit 0 of each write is used, and data bits 6:1 have no effect.
- R2: The first of the five writes supplies bit 0 of the committed word, and the fifth write supplies bit 4.
- R3: On the fifth write, address bits 14:13 choose the destination: 0 = control, 1 = character bank 0, 2 = character bank 1, 3 = program bank. The address bits of the first four writes do not matter, and the other three registers keep their values.
- R4: After a commit the bit count starts again from zero, so the next five writes form a new, independent word.
- R5: An accepted upper-half write with data bit 7 set clears the partial word and the bit count. It also sets control bits 3:2 to 1 and keeps control bits 4 and 1:0. The bank registers do not change.
- R6: Writes with address bit 15 = 0 have no effect. They change neither the registers nor the progress of a partial word.
- R7: Mirroring mode 0 (control bits 1:0 = 0) maps every nametable address to page 0, and mode 1 maps every one to page 1.
- R8: Mirroring mode 2 (vertical) gives page select = picture address bit 10, so 0x2000 and 0x2800 share a page and 0x2400 and 0x2C00 share the other page.
- R9: Mirroring mode 3 (horizontal) gives page select = picture address bit 11, so 0x2000 and 0x2400 share a page and 0x2800 and 0x2C00 share the other page.
- R10: After reset the control word is 0x0C and all three bank registers are 0. The mirroring is then single-screen page 0, so 0x2000 and 0x2400 resolve to the same page.
- R11: wr_ready stays high at all times after reset, and a write is taken in any cycle where wr_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU write present this cycle |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-unit address for the nametable lookup |
| ciram_a10 | output | 1 | Physical nametable page select |
| ctrl_q | output | 5 | Control register value |
| chr0_q | output | 5 | Character bank 0 register value |
| chr1_q | output | 5 | Character bank 1 register value |
| prg_q | output | 5 | Program bank register value |

## Verification
The assertions run on every cycle. They check the bit counter: it stays in range, it steps by one per plain write, and it returns to zero after the fifth write or an abort write. They also check that lower-half writes and the abort write leave the bank registers alone, that the abort forces the control mode bits, that ready never drops, and that the single-screen modes drive a fixed page. Only the bench's scenarios can show the values themselves. These are bit ordering, destination selection, the ignored upper data bits, a partial word surviving interleaved lower-half writes, and the page pattern across all four nametable windows in each mode.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    DST_CTRL = 2'd0,
    DST_CHR0 = 2'd1,
    DST_CHR1 = 2'd2,
    DST_PRG  = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  localparam int NUM_DEST = 4;
endpackage

// File: rtl/serial_accum.sv
module serial_accum #(
  parameter int REG_W = 5,
  localparam int CNT_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             abort,
  input  logic             bit_in,
  output logic             commit,
  output logic [REG_W-1:0] word,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-2:0] shift_q;
  logic [REG_W-1:0] shifted;
  logic             last;

  assign last    = (count == LAST);
  assign commit  = take && !abort && last;
  assign word    = {bit_in, shift_q};
  assign shifted = {bit_in, shift_q} >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      count   <= '0;
    end else if (take) begin
      if (abort || last) begin
        shift_q <= '0;
        count   <= '0;
      end else begin
        shift_q <= shifted[REG_W-2:0];
        count   <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int              REG_W     = 5,
  parameter logic [REG_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [REG_W-1:0] ABORT_OR  = 5'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  dest_e            dest,
  input  logic [REG_W-1:0] word,
  input  logic             soft_rst,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] chr0,
  output logic [REG_W-1:0] chr1,
  output logic [REG_W-1:0] prg
);
  logic [REG_W-1:0] bank_q [NUM_DEST];

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_reg
    localparam logic [REG_W-1:0] INIT = (g == 0) ? CTRL_INIT : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[g] <= INIT;
      else if (g == 0 && soft_rst)
        bank_q[g] <= bank_q[g] | ABORT_OR;
      else if (commit && dest == dest_e'(g))
        bank_q[g] <= word;
    end
  end

  assign ctrl = bank_q[DST_CTRL];
  assign chr0 = bank_q[DST_CHR0];
  assign chr1 = bank_q[DST_CHR1];
  assign prg  = bank_q[DST_PRG];
endmodule

// File: rtl/mirror_sel.sv
module mirror_sel
  import mapper_pkg::*;
#(
  parameter int PPU_AW = 14
) (
  input  logic [PPU_AW-1:0] ppu_addr,
  input  mirror_e           mode,
  output logic              page
);
  always_comb begin
    unique case (mode)
      MIR_ONE_LO: page = 1'b0;
      MIR_ONE_HI: page = 1'b1;
      MIR_VERT:   page = ppu_addr[10];
      MIR_HORZ:   page = ppu_addr[11];
      default:    page = 1'b0;
    endcase
  end
endmodule

// File: rtl/serial_mapper_ctrl.sv
module serial_mapper_ctrl
  import mapper_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int CPU_AW = 16,
  parameter int CPU_DW = 8,
  parameter int PPU_AW = 14,
  localparam int CNT_W = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [CPU_DW-1:0] wr_data,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic              ciram_a10,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  chr0_q,
  output logic [REG_W-1:0]  chr1_q,
  output logic [REG_W-1:0]  prg_q
);
  logic             take;
  logic             abort;
  logic             commit;
  logic [REG_W-1:0] word;
  logic [CNT_W-1:0] acc_count;
  dest_e            dest;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && wr_ready && wr_addr[CPU_AW-1];
  assign abort    = wr_data[CPU_DW-1];
  assign dest     = dest_e'(wr_addr[CPU_AW-2:CPU_AW-3]);

  serial_accum #(.REG_W(REG_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .abort  (abort),
    .bit_in (wr_data[0]),
    .commit (commit),
    .word   (word),
    .count  (acc_count)
  );

  mapper_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .dest     (dest),
    .word     (word),
    .soft_rst (take && abort),
    .ctrl     (ctrl_q),
    .chr0     (chr0_q),
    .chr1     (chr1_q),
    .prg      (prg_q)
  );

  mirror_sel #(.PPU_AW(PPU_AW)) u_mirror (
    .ppu_addr (ppu_addr),
    .mode     (mirror_e'(ctrl_q[1:0])),
    .page     (ciram_a10)
  );
endmodule

// File: rtl/mapper_ctrl_chk.sv
module mapper_ctrl_chk #(
  parameter int REG_W  = 5,
  parameter int CPU_AW = 16,
  parameter int CPU_DW = 8,
  parameter int PPU_AW = 14,
  localparam int CNT_W = $clog2(REG_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [CPU_AW-1:0] wr_addr,
  input logic [CPU_DW-1:0] wr_data,
  input logic [PPU_AW-1:0] ppu_addr,
  input logic              ciram_a10,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  chr0_q,
  input logic [REG_W-1:0]  chr1_q,
  input logic [REG_W-1:0]  prg_q,
  input logic [CNT_W-1:0]  acc_count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic hi_wr;
  assign hi_wr = wr_valid && wr_addr[CPU_AW-1];

  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_count <= LAST);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr && !wr_data[CPU_DW-1] && acc_count != LAST |=> acc_count == $past(acc_count) + 1'b1);

  // R4
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr && acc_count == LAST |=> acc_count == '0);

  // R5
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr && wr_data[CPU_DW-1] |=> acc_count == '0 && ctrl_q[3:2] == 2'b11
      && $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q));

  // R6
  low_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(acc_count) && $stable(ctrl_q) && $stable(chr0_q)
      && $stable(chr1_q) && $stable(prg_q));

  // R7
  single_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] == 1'b0 |-> ciram_a10 == ctrl_q[0]);

  // R8
  vert_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1:0] == 2'd2 && ppu_addr[11:10] == 2'b10 |-> !ciram_a10);

  // R9
  horz_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1:0] == 2'd3 && ppu_addr[11:10] == 2'b10 |-> ciram_a10);
endmodule

bind serial_mapper_ctrl mapper_ctrl_chk u_chk (.*);

// File: tb/serial_mapper_ctrl_test.sv
module serial_mapper_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [13:0] ppu_addr = '0;
  logic        ciram_a10;
  logic [4:0]  ctrl_q, chr0_q, chr1_q, prg_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  serial_mapper_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ppu_addr(ppu_addr),
    .ciram_a10(ciram_a10), .ctrl_q(ctrl_q), .chr0_q(chr0_q),
    .chr1_q(chr1_q), .prg_q(prg_q)
  );

  // {dest[1:0], value[4:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'd1, 5'h15}, {2'd2, 5'h0A}, {2'd3, 5'h1F}, {2'd1, 5'h01},
    {2'd3, 5'h10}, {2'd0, 5'h13}, {2'd2, 5'h1E}, {2'd0, 5'h0C}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 8'h00;
  endtask

  task automatic load(logic [1:0] dest, logic [4:0] val);
    for (int i = 0; i < 5; i++)
      bus_wr({1'b1, dest, 13'h01F0}, {1'b0, 6'(6'h2B ^ i), val[i]});
  endtask

  function automatic logic [4:0] pick(logic [1:0] dest);
    case (dest)
      2'd0: return ctrl_q;
      2'd1: return chr0_q;
      2'd2: return chr1_q;
      default: return prg_q;
    endcase
  endfunction

  task automatic page(string req, logic [13:0] a, logic exp);
    ppu_addr = a;
    #1;
    check(req, {7'd0, ciram_a10}, {7'd0, exp});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R11 ready
    check("R10 ctrl", {3'd0, ctrl_q}, 8'h0C);
    check("R10 chr0", {3'd0, chr0_q}, 8'h00);
    check("R10 chr1", {3'd0, chr1_q}, 8'h00);
    check("R10 prg",  {3'd0, prg_q},  8'h00);
    check("R11 ready", {7'd0, wr_ready}, 8'h01);
    page("R10 page 2000", 14'h2000, 1'b0);
    page("R10 page 2400", 14'h2400, 1'b0);

    // R1 R2 R3 R4: table walk
    foreach (VEC[k]) begin
      load(VEC[k][6:5], VEC[k][4:0]);
      check("R1 R2 R3 R4 table", {3'd0, pick(VEC[k][6:5])}, {3'd0, VEC[k][4:0]});
    end
    // R3 other registers kept: last values per destination
    check("R3 chr0 kept", {3'd0, chr0_q}, 8'h01);
    check("R3 prg kept",  {3'd0, prg_q},  8'h10);

    // R6: lower-half writes between serial bits
    bus_wr(16'hC000, 8'h00);
    bus_wr(16'hC000, 8'h01);
    bus_wr(16'h6000, 8'h01);
    bus_wr(16'h2000, 8'h81);
    bus_wr(16'h7FFF, 8'h01);
    check("R6 chr1 untouched", {3'd0, chr1_q}, 8'h1E);
    check("R6 ctrl untouched", {3'd0, ctrl_q}, 8'h0C);
    bus_wr(16'hC000, 8'h01);
    bus_wr(16'hC000, 8'h00);
    bus_wr(16'hC000, 8'h01);
    check("R6 partial word kept", {3'd0, chr1_q}, 8'h16);

    // R5: abort mid-sequence
    load(2'd0, 5'h11);
    check("R5 setup ctrl", {3'd0, ctrl_q}, 8'h11);
    bus_wr(16'hE000, 8'h01);
    bus_wr(16'hE000, 8'h01);
    bus_wr(16'hE000, 8'h01);
    bus_wr(16'h8000, 8'h80);
    check("R5 ctrl or", {3'd0, ctrl_q}, 8'h1D);
    check("R5 prg kept", {3'd0, prg_q}, 8'h10);
    load(2'd3, 5'h15);
    check("R5 count cleared", {3'd0, prg_q}, 8'h15);

    // R7 single-screen
    load(2'd0, 5'h00);
    page("R7 lo 2C00", 14'h2C00, 1'b0);
    load(2'd0, 5'h01);
    page("R7 hi 2000", 14'h2000, 1'b1);
    page("R7 hi 2800", 14'h2800, 1'b1);
    // R8 vertical
    load(2'd0, 5'h02);
    page("R8 2000", 14'h2000, 1'b0);
    page("R8 2400", 14'h2400, 1'b1);
    page("R8 2800", 14'h2800, 1'b0);
    page("R8 2C00", 14'h2C00, 1'b1);
    // R9 horizontal
    load(2'd0, 5'h03);
    page("R9 2000", 14'h2000, 1'b0);
    page("R9 2400", 14'h2400, 1'b0);
    page("R9 2800", 14'h2800, 1'b1);
    page("R9 2C00", 14'h2C00, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule